// File: doc/BRIEF.md
# Strobe-Framed Serial Register Port

This block is a slave serial port that gives an external controller access to a small 8-bit register file over four wires: a serial clock, a strobe, a receive data line and a transmit data line. A transfer starts with an address byte, sent MSB first. Its top bit chooses the direction and its lower seven bits name a register. A strobe pulse then ends the address phase and opens a data phase of exactly eight bits. In that phase the port either takes in a byte to write, or sends out the contents of the addressed register MSB first.

The register file holds three signed DAC codes and one power-down control register. The block drives each code onto parallel outputs in two forms: the raw two's-complement value, and an offset-binary copy with the sign bit inverted. It also drives one power-down flag for each converter. The serial clock, strobe and receive line pass through flop synchronizers into the system clock domain, and their edges are found there, so all logic runs on the system clock.

Top module: `strobe_serial_regif`

## Requirements
- R1: The receive line is sampled on each rising serial clock edge. Bits arrive MSB first. Bit 7 of the address byte is the direction: 1 means read and 0 means write. Bits 6..0 are the register address.
- R2: A strobe rising edge, seen after at least eight address bits, switches the port into data mode. The address byte used is the last eight bits received.
- R3: A strobe rising edge seen before eight address bits have arrived is ignored, and the address bit count restarts from zero.
- R4: For a write, the next eight rising serial clock edges shift in a byte MSB first. On the eighth edge the byte is stored in the addressed register and the port returns to address mode.
- R5: For a read, the transmit line shows bit 7 of the addressed register once the strobe is seen. Each falling serial clock edge then moves to the next lower bit. The port returns to address mode on the eighth rising edge. The transmit line is low whenever the port is in address mode.
- R6: Addresses 0x16, 0x17 and 0x18 hold the two's-complement codes for DAC lanes 0, 1 and 2. Lane i appears on bits [8i+7:8i] of the raw code output.
- R7: Address 0x19 is the power-down register. Bit i set to 1 powers down lane i. Reset sets bits 2..0 to 1. Bits 7..3 are ignored on write and read back as 0.
- R8: Each lane of the offset-binary output equals the lane's raw code with bit 7 inverted.
- R9: A read of any address that is not mapped returns 0x00. A write to any such address changes no register.
- R10: If a strobe rising edge and a serial clock rising edge are detected in the same system cycle in address mode, the address bit is taken first. A strobe that coincides with the eighth address bit is therefore accepted.
- R11: After reset all DAC codes are 0x00 and the transmit line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the controller |
| ser_stb | input | 1 | Strobe that starts the data phase |
| ser_din | input | 1 | Serial receive data |
| ser_dout | output | 1 | Serial transmit data |
| dac_code | output | 24 | Raw two's-complement codes, lane i at [8i+7:8i] |
| dac_offset | output | 24 | Offset-binary codes, lane i at [8i+7:8i] |
| dac_pwrdn | output | 3 | Power-down flags, one per lane, 1 = powered down |

## Verification
After synchronization, the strobe edge and the eighth address-bit clock edge can be detected in the same system cycle. The port must then take the bit first and judge the strobe on the completed count. The bench provokes this by raising the serial clock and the strobe together, at the same simulation time, on the eighth address bit of a write frame. It then sends the data byte and checks that the target lane's code output holds that byte. A strobe that arrives early, by contrast, must leave the register untouched, and the bench checks this too.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic {
    PHASE_ADDR = 1'b0,
    PHASE_DATA = 1'b1
  } phase_t;
endpackage

// File: rtl/ssr_sync.sv
// Multi-stage level synchronizer for a bundle of asynchronous pins.
module ssr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin,
  output logic [WIDTH-1:0] level
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= pin;
      for (int s = 1; s < STAGES; s++) begin
        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign level = pipe_q[STAGES-1];
endmodule

// File: rtl/ssr_frame_engine.sv
// Address/data framing state machine working on synchronized pin levels.
module ssr_frame_engine
  import ssr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              stb,
  input  logic              din,
  output logic              dout,
  output logic              data_mode,
  output logic              wr_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] rd_data
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  phase_t            phase_q;
  logic              sclk_q, stb_q;
  logic [DATA_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              read_q;
  logic [ADDR_W-1:0] addr_q;
  logic              dout_q;

  logic              clk_rise, clk_fall, stb_rise;
  logic [DATA_W-1:0] shift_in;
  logic [DATA_W-1:0] addr_shift_n;
  logic [CNT_W-1:0]  addr_cnt_n;
  logic              last_bit;

  assign clk_rise = sclk & ~sclk_q;
  assign clk_fall = ~sclk & sclk_q;
  assign stb_rise = stb & ~stb_q;
  assign shift_in = {shift_q[DATA_W-2:0], din};

  // Address phase: clock edge is folded in before the strobe is judged.
  assign addr_shift_n = clk_rise ? shift_in : shift_q;
  assign addr_cnt_n   = (clk_rise && cnt_q != FULL) ? cnt_q + 1'b1 : cnt_q;
  assign last_bit     = (cnt_q == FULL - 1'b1);

  assign reg_addr  = (phase_q == PHASE_DATA) ? addr_q : addr_shift_n[ADDR_W-1:0];
  assign wr_en     = (phase_q == PHASE_DATA) && clk_rise && !read_q && last_bit;
  assign wr_data   = shift_in;
  assign dout      = dout_q;
  assign data_mode = (phase_q == PHASE_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PHASE_ADDR;
      sclk_q  <= 1'b0;
      stb_q   <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
      read_q  <= 1'b0;
      addr_q  <= '0;
      dout_q  <= 1'b0;
    end else begin
      sclk_q <= sclk;
      stb_q  <= stb;
      unique case (phase_q)
        PHASE_ADDR: begin
          shift_q <= addr_shift_n;
          cnt_q   <= addr_cnt_n;
          if (stb_rise) begin
            cnt_q <= '0;
            if (addr_cnt_n == FULL) begin
              phase_q <= PHASE_DATA;
              read_q  <= addr_shift_n[DATA_W-1];
              addr_q  <= addr_shift_n[ADDR_W-1:0];
              if (addr_shift_n[DATA_W-1]) begin
                shift_q <= rd_data;
                dout_q  <= rd_data[DATA_W-1];
              end
            end
          end
        end
        PHASE_DATA: begin
          if (clk_rise) begin
            if (!read_q) shift_q <= shift_in;
            if (last_bit) begin
              phase_q <= PHASE_ADDR;
              cnt_q   <= '0;
              dout_q  <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end else if (clk_fall && read_q) begin
            shift_q <= {shift_q[DATA_W-2:0], 1'b0};
            dout_q  <= shift_q[DATA_W-2];
          end
        end
        default: phase_q <= PHASE_ADDR;
      endcase
    end
  end
endmodule

// File: rtl/ssr_reg_bank.sv
// DAC code registers and power-down control register.
module ssr_reg_bank #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int NUM_DAC  = 3,
  parameter int DAC_BASE = 22
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [DATA_W-1:0]              rd_data,
  output logic [NUM_DAC-1:0][DATA_W-1:0] code,
  output logic [NUM_DAC-1:0]             pwrdn
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(DAC_BASE + NUM_DAC);

  logic [NUM_DAC-1:0] lane_hit;
  logic               ctrl_hit;

  for (genvar g = 0; g < NUM_DAC; g++) begin : g_hit
    assign lane_hit[g] = (reg_addr == ADDR_W'(DAC_BASE + g));
  end
  assign ctrl_hit = (reg_addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code  <= '0;
      pwrdn <= '1;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_DAC; i++) begin
        if (lane_hit[i]) code[i] <= wr_data;
      end
      if (ctrl_hit) pwrdn <= wr_data[NUM_DAC-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (ctrl_hit) rd_data = {{(DATA_W-NUM_DAC){1'b0}}, pwrdn};
    for (int i = 0; i < NUM_DAC; i++) begin
      if (lane_hit[i]) rd_data = code[i];
    end
  end
endmodule

// File: rtl/strobe_serial_regif.sv
module strobe_serial_regif #(
  parameter int NUM_DAC     = 3,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int DAC_BASE    = 22,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ser_clk,
  input  logic                      ser_stb,
  input  logic                      ser_din,
  output logic                      ser_dout,
  output logic [NUM_DAC*DATA_W-1:0] dac_code,
  output logic [NUM_DAC*DATA_W-1:0] dac_offset,
  output logic [NUM_DAC-1:0]        dac_pwrdn
);
  logic [2:0]                     pin_level;
  logic                           eng_wr;
  logic                           eng_data_mode;
  logic [ADDR_W-1:0]              eng_addr;
  logic [DATA_W-1:0]              eng_wdata;
  logic [DATA_W-1:0]              bank_rdata;
  logic [NUM_DAC-1:0][DATA_W-1:0] lane_code;

  ssr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   ({ser_clk, ser_stb, ser_din}),
    .level (pin_level)
  );

  ssr_frame_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (pin_level[2]),
    .stb       (pin_level[1]),
    .din       (pin_level[0]),
    .dout      (ser_dout),
    .data_mode (eng_data_mode),
    .wr_en     (eng_wr),
    .reg_addr  (eng_addr),
    .wr_data   (eng_wdata),
    .rd_data   (bank_rdata)
  );

  ssr_reg_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_DAC(NUM_DAC), .DAC_BASE(DAC_BASE)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (eng_wr),
    .reg_addr (eng_addr),
    .wr_data  (eng_wdata),
    .rd_data  (bank_rdata),
    .code     (lane_code),
    .pwrdn    (dac_pwrdn)
  );

  for (genvar g = 0; g < NUM_DAC; g++) begin : g_lane
    assign dac_code[g*DATA_W +: DATA_W]   = lane_code[g];
    assign dac_offset[g*DATA_W +: DATA_W] = {~lane_code[g][DATA_W-1], lane_code[g][DATA_W-2:0]};
  end
endmodule

// File: rtl/ssr_regif_checker.sv
module ssr_regif_checker #(
  parameter int NUM_DAC  = 3,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 7,
  parameter int DAC_BASE = 22
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ser_dout,
  input logic                      eng_data_mode,
  input logic                      eng_wr,
  input logic [ADDR_W-1:0]         eng_addr,
  input logic [DATA_W-1:0]         eng_wdata,
  input logic [NUM_DAC*DATA_W-1:0] dac_code,
  input logic [NUM_DAC-1:0]        dac_pwrdn
);
  AST_DOUT_LOW_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_data_mode |-> !ser_dout); // R5

  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_wr |=> $stable(dac_code)); // R4

  AST_PWRDN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_wr |=> $stable(dac_pwrdn)); // R7

  AST_LANE0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_wr && eng_addr == ADDR_W'(DAC_BASE)) |=> dac_code[DATA_W-1:0] == $past(eng_wdata)); // R6

  AST_PWRDN_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> dac_pwrdn == '1); // R7

  AST_WRITE_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    eng_wr |-> eng_data_mode); // R4
endmodule

bind strobe_serial_regif ssr_regif_checker #(
  .NUM_DAC(NUM_DAC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DAC_BASE(DAC_BASE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ser_dout      (ser_dout),
  .eng_data_mode (eng_data_mode),
  .eng_wr        (eng_wr),
  .eng_addr      (eng_addr),
  .eng_wdata     (eng_wdata),
  .dac_code      (dac_code),
  .dac_pwrdn     (dac_pwrdn)
);

// File: tb/tb_strobe_serial_regif.sv
module tb_strobe_serial_regif;
  localparam int HALF = 6;
  localparam int NV   = 14;
  // {read, addr[6:0], wdata[7:0], expected[7:0]}
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 7'h16, 8'h5A, 8'h00},
    {1'b0, 7'h17, 8'h80, 8'h00},
    {1'b0, 7'h18, 8'h7F, 8'h00},
    {1'b1, 7'h19, 8'h00, 8'h07},
    {1'b1, 7'h16, 8'h00, 8'h5A},
    {1'b1, 7'h17, 8'h00, 8'h80},
    {1'b1, 7'h18, 8'h00, 8'h7F},
    {1'b0, 7'h19, 8'h05, 8'h00},
    {1'b1, 7'h19, 8'h00, 8'h05},
    {1'b0, 7'h19, 8'hFA, 8'h00},
    {1'b1, 7'h19, 8'h00, 8'h02},
    {1'b0, 7'h20, 8'hFF, 8'h00},
    {1'b1, 7'h20, 8'h00, 8'h00},
    {1'b1, 7'h15, 8'h00, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0, ser_stb = 1'b0, ser_din = 1'b0;
  logic        ser_dout;
  logic [23:0] dac_code, dac_offset;
  logic [2:0]  dac_pwrdn;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  strobe_serial_regif dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_stb(ser_stb),
    .ser_din(ser_din), .ser_dout(ser_dout), .dac_code(dac_code),
    .dac_offset(dac_offset), .dac_pwrdn(dac_pwrdn)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_din = b;
    wait_cyc(HALF);
    ser_clk = 1'b1;
    wait_cyc(HALF);
    ser_clk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_stb();
    wait_cyc(HALF);
    ser_stb = 1'b1;
    wait_cyc(HALF);
    ser_stb = 1'b0;
    wait_cyc(HALF);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      v[i] = ser_dout;
      ser_clk = 1'b1;
      wait_cyc(HALF);
      ser_clk = 1'b0;
      wait_cyc(HALF);
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d);
    send_byte({1'b0, a});
    pulse_stb();
    send_byte(d);
    wait_cyc(HALF);
  endtask

  task automatic do_read(input logic [6:0] a, output logic [7:0] d);
    send_byte({1'b1, a});
    pulse_stb();
    recv_byte(d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);
    // R11 / R7 / R8 reset state
    check("R11 code reset", dac_code, 24'h0);
    check("R11 dout reset", ser_dout, 1'b0);
    check("R7 pwrdn reset", dac_pwrdn, 3'b111);
    check("R8 offset reset", dac_offset, 24'h808080);

    // Vector table: R1 R2 R4 R5 R6 R7 R9
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][23]) begin
        do_read(VEC[k][22:16], rd);
        check("R5 read data", rd, VEC[k][7:0]);
      end else begin
        do_write(VEC[k][22:16], VEC[k][15:8]);
      end
    end
    check("R5 dout low after read", ser_dout, 1'b0);
    check("R6 lane codes", dac_code, 24'h7F805A);
    check("R8 offset lanes", dac_offset, 24'hFF00DA);
    check("R7 pwrdn upper ignored", dac_pwrdn, 3'b010);

    // R3: early strobe ignored, count restarts; 5+3 bits would form write 0x17
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    pulse_stb();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    pulse_stb();
    send_byte(8'h3C);
    wait_cyc(HALF);
    check("R3 early strobe no write", dac_code[15:8], 8'h80);
    check("R3 dout stays low", ser_dout, 1'b0);

    // R10: strobe rises together with the eighth address bit
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    ser_din = 1'b0;
    wait_cyc(HALF);
    ser_clk = 1'b1;
    ser_stb = 1'b1;
    wait_cyc(HALF);
    ser_clk = 1'b0;
    ser_stb = 1'b0;
    wait_cyc(HALF);
    send_byte(8'h11);
    wait_cyc(HALF);
    check("R10 coincident strobe accepted", dac_code[23:16], 8'h11);
    check("R8 offset lane2", dac_offset[23:16], 8'h91);

    // R2: more than eight address bits, last eight used
    send_byte(8'hFF);
    do_write(7'h16, 8'hC3);
    check("R2 last eight bits address", dac_code, 24'h1180C3);

    // R1 / R5: read of negative code MSB-first
    do_read(7'h16, rd);
    check("R1 read back lane0", rd, 8'hC3);

    // Reset restores power-down
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    check("R7 pwrdn after second reset", dac_pwrdn, 3'b111);
    check("R11 code after second reset", dac_code, 24'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule